// File: doc/BRIEF.md
# Handshaked Sequential Divider Controller

This block takes unsigned divide requests from a client and has them worked out by a separate multi-cycle divider. The two units share one clock. When a request arrives, the controller latches both operands and raises a start level toward the divider. It keeps start high until the divider answers with busy. It then drops start and waits for busy to fall. On that edge it captures the quotient and remainder, and it tells the client with a one-cycle done pulse.

Because the controller reacts only to the busy level, it never counts cycles and never relies on a fixed worker latency. The divider is a restoring, bit-serial design that produces one quotient bit per clock. A zero divisor is the short case: it finishes in a single busy cycle.

On the client side, requests use valid/ready. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle, so the client has to hold its request until ready returns. The result side has no back-pressure. `done` is a single-cycle strobe, and the results are held until the next completion.

Top module: `seq_div_top`

## Requirements
- R1: A synchronous active-high `rst` returns both machines to idle: after the reset edge `req_ready` is 1, `done` is 0, and the internal start and busy levels are 0.
- R2: A request is accepted only on an edge where both `req_valid` and `req_ready` are 1. `req_ready` is 1 only in idle, so `req_valid` has no effect while an operation is in progress and causes no extra completion.
- R3: The controller raises start after accepting a request and keeps it high until it samples busy high.
- R4: Once busy has been sampled high, start is low on the next cycle. The controller then waits until busy is low before it consumes the result.
- R5: The divider raises busy on the clock after it samples start high while idle, and it ignores start while busy.
- R6: For a non-zero divisor, `quotient` = floor(`dividend`/`divisor`) and `remainder` = `dividend` mod `divisor`, both unsigned and WIDTH bits wide.
- R7: For a zero divisor, `quotient` is all ones and `remainder` equals `dividend`. The edge that accepts the request counts as edge 0, and `done` is high in the cycle after edge 3.
- R8: For a non-zero divisor, `done` is high in the cycle after edge WIDTH+3, counted the same way as in R7.
- R9: `done` is high for exactly one cycle per accepted request.
- R10: `quotient` and `remainder` change only in the cycle in which `done` is high, and they hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client offers a divide request |
| req_ready | output | 1 | Controller idle, able to take a request |
| dividend | input | WIDTH | Unsigned numerator, sampled on acceptance |
| divisor | input | WIDTH | Unsigned denominator, sampled on acceptance |
| done | output | 1 | One-cycle completion strobe |
| quotient | output | WIDTH | Captured quotient |
| remainder | output | WIDTH | Captured remainder |

## Verification
The bench builds the block with WIDTH = 8. At that width the extreme operands, such as 255/1, 255/255, a dividend below the divisor, 0/0 and a non-zero value over 0, are easy to reach, and each operation is short enough for many back-to-back requests. The expected latency is checked for both the zero-divisor path and the full-length path. A stray `req_valid` pulse is driven in the middle of an operation to confirm that it produces no extra completion. The outputs are also compared several cycles after a `done` pulse to confirm that they hold.

// File: rtl/seq_div_pkg.sv
package seq_div_pkg;
  typedef enum logic [1:0] {
    CS_IDLE,
    CS_LAUNCH,
    CS_AWAIT,
    CS_DELIVER
  } ctrl_state_e;
endpackage

// File: rtl/seq_div_worker.sv
module seq_div_worker #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] num_in,
  input  logic [WIDTH-1:0] den_in,
  output logic             busy,
  output logic [WIDTH-1:0] quo_out,
  output logic [WIDTH-1:0] rem_out
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [WIDTH-1:0] quo_q, rem_q, den_q;
  logic [CW-1:0]    left_q;
  logic             busy_q;
  logic [WIDTH:0]   trial, sub;
  logic             fits;

  // shift the next dividend bit into the partial remainder
  assign trial = {rem_q, quo_q[WIDTH-1]};
  assign sub   = trial - {1'b0, den_q};
  assign fits  = trial >= {1'b0, den_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      left_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        den_q  <= den_in;
        if (den_in == '0) begin
          quo_q  <= '1;
          rem_q  <= num_in;
          left_q <= '0;
        end else begin
          quo_q  <= num_in;
          rem_q  <= '0;
          left_q <= CW'(WIDTH);
        end
      end
    end else if (left_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      quo_q  <= {quo_q[WIDTH-2:0], fits};
      rem_q  <= fits ? sub[WIDTH-1:0] : trial[WIDTH-1:0];
      left_q <= left_q - 1'b1;
    end
  end

  assign busy    = busy_q;
  assign quo_out = quo_q;
  assign rem_out = rem_q;
endmodule

// File: rtl/seq_div_ctrl.sv
module seq_div_ctrl
  import seq_div_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             done,
  output logic [WIDTH-1:0] res_q,
  output logic [WIDTH-1:0] res_r,
  output logic             wk_start,
  input  logic             wk_busy,
  output logic [WIDTH-1:0] wk_a,
  output logic [WIDTH-1:0] wk_b,
  input  logic [WIDTH-1:0] wk_q,
  input  logic [WIDTH-1:0] wk_r
);
  ctrl_state_e      state;
  logic [WIDTH-1:0] a_q, b_q, q_q, r_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= CS_IDLE;
      a_q   <= '0;
      b_q   <= '0;
      q_q   <= '0;
      r_q   <= '0;
    end else begin
      unique case (state)
        CS_IDLE: if (req_valid) begin
          a_q   <= op_a;
          b_q   <= op_b;
          state <= CS_LAUNCH;
        end
        CS_LAUNCH: if (wk_busy) state <= CS_AWAIT;
        CS_AWAIT: if (!wk_busy) begin
          q_q   <= wk_q;
          r_q   <= wk_r;
          state <= CS_DELIVER;
        end
        CS_DELIVER: state <= CS_IDLE;
        default: state <= CS_IDLE;
      endcase
    end
  end

  assign req_ready = (state == CS_IDLE);
  assign wk_start  = (state == CS_LAUNCH);
  assign done      = (state == CS_DELIVER);
  assign wk_a      = a_q;
  assign wk_b      = b_q;
  assign res_q     = q_q;
  assign res_r     = r_q;
endmodule

// File: rtl/seq_div_top.sv
module seq_div_top #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  logic             start_w, busy_w;
  logic [WIDTH-1:0] a_w, b_w, q_w, r_w;

  seq_div_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready),
    .op_a(dividend), .op_b(divisor),
    .done(done), .res_q(quotient), .res_r(remainder),
    .wk_start(start_w), .wk_busy(busy_w),
    .wk_a(a_w), .wk_b(b_w), .wk_q(q_w), .wk_r(r_w)
  );

  seq_div_worker #(.WIDTH(WIDTH)) u_worker (
    .clk(clk), .rst(rst), .start(start_w),
    .num_in(a_w), .den_in(b_w),
    .busy(busy_w), .quo_out(q_w), .rem_out(r_w)
  );
endmodule

// File: rtl/seq_div_chk.sv
module seq_div_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             req_ready,
  input logic             done,
  input logic [WIDTH-1:0] quotient,
  input logic [WIDTH-1:0] remainder,
  input logic             start_w,
  input logic             busy_w
);
  // R1
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (req_ready && !done && !start_w && !busy_w));
  // R2
  a_r2_no_ready_busy: assert property (@(posedge clk) disable iff (rst)
    busy_w |-> !req_ready);
  // R3
  a_r3_start_held: assert property (@(posedge clk) disable iff (rst)
    (start_w && !busy_w) |=> start_w);
  // R4
  a_r4_start_drop: assert property (@(posedge clk) disable iff (rst)
    (start_w && busy_w) |=> !start_w);
  // R5
  a_r5_busy_rise: assert property (@(posedge clk) disable iff (rst)
    (start_w && !busy_w) |=> busy_w);
  // R9
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !($stable(quotient) && $stable(remainder)) |-> done);
endmodule

bind seq_div_top seq_div_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .done(done),
  .quotient(quotient), .remainder(remainder),
  .start_w(start_w), .busy_w(busy_w)
);

// File: tb/test_seq_div_top.sv
`timescale 1ns/1ps
module test_seq_div_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready, done;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic [W-1:0] quotient, remainder;

  int tests = 0, fails = 0, cyc = 0, dones = 0, sent = 0;
  logic [W-1:0] exp_q[$], exp_r[$];
  int           exp_lat[$], acc_cyc[$];
  logic [W-1:0] last_q = '0, last_r = '0;

  seq_div_top #(.WIDTH(W)) i_seq_div_top (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .dividend(dividend), .divisor(divisor), .done(done),
    .quotient(quotient), .remainder(remainder)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: push expectations, then hand over the request
  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    dividend  = a;
    divisor   = b;
    if (b == 0) begin
      exp_q.push_back('1);
      exp_r.push_back(a);
      exp_lat.push_back(4);        // R7: after edge 3
    end else begin
      exp_q.push_back(a / b);
      exp_r.push_back(a % b);
      exp_lat.push_back(W + 4);    // R8: after edge W+3
    end
    acc_cyc.push_back(cyc);
    sent++;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: compare each completion with the oldest expectation
  always @(negedge clk) begin
    if (!rst && done) begin
      dones++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected done", 1, 0);
      end else begin
        logic [W-1:0] eq, er;
        int el, ac;
        eq = exp_q.pop_front(); er = exp_r.pop_front();
        el = exp_lat.pop_front(); ac = acc_cyc.pop_front();
        check(quotient == eq, "R6/R7 quotient", quotient, eq);
        check(remainder == er, "R6/R7 remainder", remainder, er);
        check(cyc - ac == el, "R7/R8 latency", cyc - ac, el);
        last_q = eq; last_r = er;
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    check(done == 1'b0, "R1 done after reset", done, 0);

    send(8'd100, 8'd7);
    // R2: stray request while busy must be ignored
    repeat (2) @(negedge clk);
    check(req_ready == 1'b0, "R2 ready low while busy", req_ready, 0);
    req_valid = 1'b1; dividend = 8'd9; divisor = 8'd3;
    @(negedge clk);
    req_valid = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    // R10: results hold after done
    repeat (5) @(negedge clk);
    check(quotient == last_q, "R10 quotient hold", quotient, last_q);
    check(remainder == last_r, "R10 remainder hold", remainder, last_r);
    // R9: one done per request so far
    check(dones == sent, "R9 done count", dones, sent);

    send(8'd255, 8'd1);
    send(8'd0, 8'd5);
    send(8'd7, 8'd9);
    send(8'd255, 8'd255);
    send(8'd200, 8'd0);   // R7 zero divisor
    send(8'd0, 8'd0);
    send(8'd128, 8'd3);
    for (int i = 0; i < 20; i++)
      send(8'((i * 37 + 11) % 256), 8'((i * 13) % 17));
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(dones == sent, "R9 total done count", dones, sent);
    check(quotient == last_q, "R10 final hold", quotient, last_q);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule